// File: doc/BRIEF.md
# Reset-Safe Stream FIFO

A single-clock first-in first-out buffer between two AXI4-Stream links. Each beat carries a data word and an end-of-packet marker. An upstream beat is taken when the input valid and ready are both high at a rising clock edge. A stored beat is handed on when the output valid and the downstream ready are both high. Beats are kept in a plain storage array with no reset, so the array can map onto block memory. A write pointer and a read pointer, both cleared by reset, index that array.

The design is built around what happens at reset. The address that steers a write into the array comes straight from the reset-cleared write pointer. No separate address register sits in between, so a beat offered in the very first cycle after reset is released lands in slot zero and is not lost. A parameter picks how the input behaves just after reset. In immediate mode it accepts in that first cycle. In hold mode it refuses for exactly one cycle and then follows the fill level. Both sides of the stream share one synchronous active-low reset. A reset in the middle of traffic discards every beat stored before it.

Top module: `stream_fifo_safe`

## Requirements
- R1: While `rst_n` is low, `s_tready` and `m_tvalid` are both low.
- R2: In immediate mode (`RELEASE_MODE` = 0), `s_tready` is high in the first cycle after `rst_n` rises. A beat offered in that cycle is stored and is the first beat to leave the FIFO.
- R3: In hold mode (`RELEASE_MODE` = 1), `s_tready` is low in the first cycle after `rst_n` rises and high in the second cycle, when the FIFO is empty. A beat accepted in the second cycle appears at the output in the third cycle.
- R4: Beats leave in the order they were accepted, with `m_tdata` and `m_tlast` equal to the accepted `s_tdata` and `s_tlast`.
- R5: Outside reset, `s_tready` is high exactly when fewer than 2^`ADDR_W` beats are stored. No beat is accepted while the FIFO is full.
- R6: Outside reset, `m_tvalid` is high exactly when at least one beat is stored. It rises in the cycle right after the edge that accepted the first beat.
- R7: A cycle in which a beat is both accepted and handed on leaves the number of stored beats unchanged.
- R8: After a reset applied mid-stream, with valid held high throughout, no beat from before the reset appears. Every beat accepted after the reset appears exactly once, in order.
- R9: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset shared by both stream sides |
| s_tdata | input | DATA_W | Upstream beat data |
| s_tlast | input | 1 | Upstream end-of-packet marker |
| s_tvalid | input | 1 | Upstream beat offered |
| s_tready | output | 1 | FIFO can take a beat this cycle |
| m_tdata | output | DATA_W | Data of the oldest stored beat |
| m_tlast | output | 1 | End-of-packet marker of the oldest stored beat |
| m_tvalid | output | 1 | A stored beat is on offer |
| m_tready | input | 1 | Downstream takes the offered beat |

## Verification
Both ready and valid are decoded from the pointers without a further register. A beat accepted at one rising edge therefore shows as `m_tvalid` high, and as any change in `s_tready`, in the cycle that starts at that same edge. A reset sampled at an edge takes effect in the cycle that follows. The bench drives inputs at the falling edge and reads the outputs one nanosecond later. It compares them against an arithmetic queue model that holds the state as of the last rising edge, and it updates that model only with the handshakes that will complete at the next rising edge. The first cycles after reset release are checked on their own, for both release modes side by side.

// File: rtl/sfifo_pkg.sv
// Shared definitions for the reset-safe stream FIFO.
// Assumes: nothing beyond a single clock domain.
package sfifo_pkg;
    // How the input side behaves in the first cycle after reset release
    typedef enum logic {
        REL_IMMEDIATE = 1'b0,   // accept at once; write address is the cleared pointer
        REL_HOLD_ONE  = 1'b1    // refuse for exactly one cycle, then follow fill level
    } release_mode_e;
endpackage

// File: rtl/sfifo_ptr_ctrl.sv
// Write/read pointer pair with full and empty decode.
// Pointers are one bit wider than the address; equal pointers mean empty,
// pointers equal except in the top bit mean full.
// Assumes: the caller never raises wr_en when full nor rd_en when empty.
module sfifo_ptr_ctrl #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              full,
    output logic              empty
);
    localparam logic [ADDR_W:0] PTR_STEP = 1;

    logic [ADDR_W:0] wr_q;
    logic [ADDR_W:0] rd_q;

    // Advance the write pointer per accepted beat; cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_q <= '0;
        else if (wr_en) wr_q <= wr_q + PTR_STEP;
    end

    // Advance the read pointer per delivered beat; cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_q + PTR_STEP;
    end

    // Addresses taken straight from the cleared pointers, no extra stage
    assign wr_addr = wr_q[ADDR_W-1:0];
    assign rd_addr = rd_q[ADDR_W-1:0];

    // Fill decode from pointer comparison
    assign empty = (wr_q == rd_q);
    assign full  = (wr_q[ADDR_W] != rd_q[ADDR_W]) &&
                   (wr_q[ADDR_W-1:0] == rd_q[ADDR_W-1:0]);
endmodule

// File: rtl/sfifo_store.sv
// Beat storage: a plain array with one write port and an asynchronous read.
// Deliberately carries no reset so that it can map onto memory macros.
// Assumes: the address is valid whenever we is high.
module sfifo_store #(
    parameter int WIDTH  = 9,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    // Write one beat per enabled cycle; contents survive reset untouched
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the slot at the read address
    assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_release_gate.sv
// Decides whether the input side may open, covering reset and the
// optional one-cycle settle after reset release.
// Assumes: rst_n is synchronous and shared with the rest of the FIFO.
module sfifo_release_gate
    import sfifo_pkg::*;
#(
    parameter release_mode_e MODE = REL_IMMEDIATE
) (
    input  logic clk,
    input  logic rst_n,
    output logic accept_open
);
    localparam logic HOLD = (MODE == REL_HOLD_ONE);

    logic settle_q;

    // Set during reset, cleared one edge after release
    always_ff @(posedge clk) begin
        if (!rst_n) settle_q <= 1'b1;
        else        settle_q <= 1'b0;
    end

    // Closed during reset; in hold mode also closed for the settle cycle
    assign accept_open = rst_n & ~(HOLD & settle_q);
endmodule

// File: rtl/stream_fifo_safe.sv
// Single-clock stream FIFO whose write address is correct from the first
// cycle after reset. The release behaviour is chosen by RELEASE_MODE.
// Assumes: both stream sides share clk and rst_n; no split reset.
module stream_fifo_safe
    import sfifo_pkg::*;
#(
    parameter int            DATA_W       = 8,
    parameter int            ADDR_W       = 3,
    parameter release_mode_e RELEASE_MODE = REL_IMMEDIATE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tlast,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready
);
    localparam int BEAT_W = DATA_W + 1;

    logic              open_in;
    logic              full;
    logic              empty;
    logic              push;
    logic              pop;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [BEAT_W-1:0] rd_beat;

    sfifo_release_gate #(.MODE(RELEASE_MODE)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_open (open_in)
    );

    sfifo_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .rd_en   (pop),
        .wr_addr (waddr),
        .rd_addr (raddr),
        .full    (full),
        .empty   (empty)
    );

    sfifo_store #(.WIDTH(BEAT_W), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (waddr),
        .wdata ({s_tlast, s_tdata}),
        .raddr (raddr),
        .rdata (rd_beat)
    );

    // Handshake decode on both stream sides
    always_comb begin
        s_tready = open_in & ~full;
        m_tvalid = rst_n & ~empty;
        push     = s_tvalid & s_tready;
        pop      = m_tvalid & m_tready;
    end

    // Split the stored beat into its fields
    assign {m_tlast, m_tdata} = rd_beat;
endmodule

// File: rtl/sfifo_chk.sv
// Property checker for stream_fifo_safe, attached by bind below.
// Keeps its own count of stored beats from the port handshakes.
module sfifo_chk
    import sfifo_pkg::*;
#(
    parameter int            DATA_W       = 8,
    parameter int            ADDR_W       = 3,
    parameter release_mode_e RELEASE_MODE = REL_IMMEDIATE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic [DATA_W-1:0] m_tdata,
    input logic              m_tlast,
    input logic              m_tvalid,
    input logic              m_tready
);
    localparam logic [ADDR_W:0] FULL_OCC = (ADDR_W+1)'(1 << ADDR_W);
    localparam logic [ADDR_W:0] ONE      = 1;
    localparam logic IMM  = (RELEASE_MODE == REL_IMMEDIATE);
    localparam logic HOLD = (RELEASE_MODE == REL_HOLD_ONE);

    logic [ADDR_W:0] occ;
    logic            acc;
    logic            dlv;

    assign acc = s_tvalid & s_tready;
    assign dlv = m_tvalid & m_tready;

    // Occupancy as seen at the ports
    always_ff @(posedge clk) begin
        if (!rst_n)          occ <= '0;
        else if (acc && !dlv) occ <= occ + ONE;
        else if (dlv && !acc) occ <= occ - ONE;
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!s_tready && !m_tvalid));

    // R2
    release_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (IMM && $rose(rst_n)) |-> s_tready);

    // R3
    release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HOLD && $rose(rst_n)) |-> !s_tready);

    // R3
    release_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HOLD && $past(rst_n) && !$past(rst_n, 2)) |-> s_tready);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == FULL_OCC) |-> !s_tready);

    // R6
    valid_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid == (occ != '0));

    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dlv) |=> m_tvalid);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
endmodule

bind stream_fifo_safe sfifo_chk #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .RELEASE_MODE (RELEASE_MODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .m_tdata  (m_tdata),
    .m_tlast  (m_tlast),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready)
);

// File: tb/sim_stream_fifo_safe.sv
module sim_stream_fifo_safe;
    import sfifo_pkg::*;

    localparam int AW    = 2;
    localparam int DEPTH = 1 << AW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] s_tdata = '0;
    logic       s_tlast = 1'b0;
    logic       s_tvalid = 1'b0;
    logic       m_tready = 1'b0;
    logic       s_tready, m_tvalid, m_tlast;
    logic [7:0] m_tdata;
    logic       s_tready1, m_tvalid1, m_tlast1;
    logic [7:0] m_tdata1;

    int n_chk = 0;
    int n_bad = 0;
    int seq = 1;
    logic [8:0] q[$];

    always #5 clk = ~clk;

    stream_fifo_safe #(.DATA_W(8), .ADDR_W(AW), .RELEASE_MODE(REL_IMMEDIATE)) u0 (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .m_tdata(m_tdata),
        .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready));

    stream_fifo_safe #(.DATA_W(8), .ADDR_W(AW), .RELEASE_MODE(REL_HOLD_ONE)) u1 (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready1), .m_tdata(m_tdata1),
        .m_tlast(m_tlast1), .m_tvalid(m_tvalid1), .m_tready(1'b1));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] beat_of(input int s);
        return {(s % 3 == 0), s[7:0]};
    endfunction

    // One cycle on u0: drive at the falling edge, compare, model the next rising edge
    task automatic cyc(input bit v, input bit r);
        logic [8:0] exp;
        s_tvalid = v;
        {s_tlast, s_tdata} = beat_of(seq);
        m_tready = r;
        #1;
        if (!rst_n) begin
            check(s_tready == 1'b0, "R1 s_tready", s_tready, 0);
            check(m_tvalid == 1'b0, "R1 m_tvalid", m_tvalid, 0);
            q.delete();
        end else begin
            check(s_tready == (q.size() < DEPTH), "R5 s_tready", s_tready, q.size() < DEPTH);
            check(m_tvalid == (q.size() != 0), "R6 m_tvalid", m_tvalid, q.size() != 0);
            if (m_tvalid && r && q.size() > 0) begin
                exp = q.pop_front();
                check({m_tlast, m_tdata} == exp, "R4 beat", {m_tlast, m_tdata}, exp);
            end
            if (v && s_tready) begin
                q.push_back({s_tlast, s_tdata});
                seq++;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [8:0] first_beat;
        logic [8:0] second_beat;
        int sz;
        @(negedge clk);
        // R1: reset with upstream valid held high
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0);

        // First cycle after release: R2 for u0, R3 for u1
        rst_n = 1'b1;
        s_tvalid = 1'b1;
        #1;
        check(s_tready == 1'b1, "R2 open at release", s_tready, 1);
        check(s_tready1 == 1'b0, "R3 closed at release", s_tready1, 0);
        first_beat = beat_of(seq);
        cyc(1'b1, 1'b0);
        #1;
        check(s_tready1 == 1'b1, "R3 open second cycle", s_tready1, 1);
        second_beat = beat_of(seq);
        cyc(1'b1, 1'b0);
        #1;
        check(m_tvalid1 == 1'b1, "R3 u1 valid", m_tvalid1, 1);
        check({m_tlast1, m_tdata1} == second_beat, "R3 u1 beat", {m_tlast1, m_tdata1}, second_beat);

        // Fill u0 beyond depth; R9 oldest beat held while stalled
        for (int i = 0; i < DEPTH + 1; i++) begin
            #1;
            check({m_tlast, m_tdata} == first_beat, "R9 held beat", {m_tlast, m_tdata}, first_beat);
            cyc(1'b1, 1'b0);
        end

        // Drain: first out is the release-cycle beat (R2)
        #1;
        check({m_tlast, m_tdata} == first_beat, "R2 first out", {m_tlast, m_tdata}, first_beat);
        for (int i = 0; i < DEPTH + 1; i++) cyc(1'b0, 1'b1);

        // R7: steady push and pop with two stored beats
        cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b0);
        for (int i = 0; i < 20; i++) begin
            sz = q.size();
            cyc(1'b1, 1'b1);
            check(q.size() == sz, "R7 occupancy", q.size(), sz);
        end

        // Sweep of valid/ready patterns
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            b = 8'(i);
            cyc(b[0] ^ b[5], b[1] ^ (b[3] & b[4]));
        end
        for (int i = 0; i < DEPTH + 1; i++) cyc(1'b0, 1'b1);

        // R8: mid-stream reset with valid held high
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0);
        rst_n = 1'b0;
        cyc(1'b1, 1'b1);
        rst_n = 1'b1;
        #1;
        check(m_tvalid == 1'b0, "R8 no stale beat", m_tvalid, 0);
        for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1);
        for (int i = 0; i < DEPTH + 2; i++) cyc(1'b0, 1'b1);
        check(q.size() == 0, "R8 all delivered", q.size(), 0);
        #1;
        check(m_tvalid == 1'b0, "R8 drained", m_tvalid, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule